// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Coherent Seconds Snapshot

The block keeps wall time as two counters: a seconds count of DATA_W bits and a milliseconds count that runs from 0 to MS_PER_SEC-1. A prescaler divides the free-running slow clock by TICK_DIV to produce one millisecond tick. The milliseconds count advances on every tick. When it rolls over, the seconds count advances on the same edge. Counting never pauses for bus activity, so the block can keep time while the rest of the system is idle.

Software reaches the counters through a small register bus. A request with the write strobe low is a read, and its data appears on `rdata_o` on the following edge. Reading the milliseconds location also copies the live seconds value into a separate shadow register on that same edge. To obtain a time value that cannot tear, software reads milliseconds first and then the shadow. Both values come from the same instant, even if the milliseconds count wraps between the two bus accesses. Writing the seconds location presets seconds, zeroes milliseconds and restarts the prescaler.

Top module: `rtc_ms_shadow`

## Requirements
- R1: The milliseconds count starts from zero at reset and after a seconds preload. It advances by one every TICK_DIV clock cycles and stays within 0 to MS_PER_SEC-1. With a preload captured at edge w, the value present before edge E is floor((E-1-w)/TICK_DIV) mod MS_PER_SEC.
- R2: On the tick that finds milliseconds at MS_PER_SEC-1, milliseconds returns to 0 and seconds increases by one on that same edge.
- R3: Seconds is DATA_W bits wide and wraps from all ones to zero.
- R4: A read of offset 0x10 returns the milliseconds count, zero-extended. On the same edge it copies live seconds into the shadow. Both values come from the state before that edge, also when a tick or rollover lands on it.
- R5: The shadow is zero after reset. Only a milliseconds read changes it: ticks, rollovers, and reads of other locations leave it as it is.
- R6: A write to offset 0x08 loads seconds with the write data, clears milliseconds and restarts the prescaler. The write takes precedence over a tick or rollover on the same edge.
- R7: Writes to offset 0x0C (shadow), offset 0x10 (milliseconds) and any unmapped offset change no state.
- R8: A read of any offset other than 0x08, 0x0C or 0x10 returns zero.
- R9: `rdata_o` is zero during reset. A read's data appears on the edge after the request, for offsets 0x08 (live seconds), 0x0C (shadow) and 0x10 (milliseconds).
- R10: Counting goes on with or without bus traffic; reads never stall or alter the counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | Write strobe; low selects a read |
| addr_i | input | 8 | Byte offset of the accessed location |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data, valid the cycle after a read |

## Verification
The critical overlap is a milliseconds read that lands on the very edge where the count wraps from MS_PER_SEC-1 to 0 and seconds steps. The bench provokes it by counting edges from a known preload. It issues the milliseconds read on exactly that edge, then reads the shadow and the live seconds. It expects the last millisecond value paired with the old seconds in the shadow, while live seconds already shows the new second. The second overlap is a seconds preload that lands on a rollover edge. It is judged by checking that the loaded value and a zero milliseconds count win, and that the next tick arrives a full prescaler period later.

// File: rtl/rtc_ms_pkg.sv
package rtc_ms_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_SEC    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SHADOW = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MS     = 8'h10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SEC,
    SEL_SHADOW,
    SEL_MS
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] addr);
    reg_sel_e sel;
    case (addr)
      OFF_SEC:    sel = SEL_SEC;
      OFF_SHADOW: sel = SEL_SHADOW;
      OFF_MS:     sel = SEL_MS;
      default:    sel = SEL_NONE;
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICK_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  // TICK_DIV == 1 degenerates to a tick every cycle
  assign tick_o = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing_chk
      // R1: ticks never come back to back; R6: a restart defers the next tick
      p_tick_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o || restart_i) |=> !tick_o)
        else $error("tick spacing violated");
    end
  endgenerate
endmodule

// File: rtl/rtc_ms_count.sv
module rtc_ms_count #(
  parameter int MS_PER_SEC = 1000,
  localparam int MS_W = $clog2(MS_PER_SEC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            clr_i,
  output logic [MS_W-1:0] ms_o,
  output logic            carry_o
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic [MS_W-1:0] ms_q;

  assign carry_o = tick_i && (ms_q == MS_LAST);
  assign ms_o    = ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ms_q <= '0;
    else if (clr_i)   ms_q <= '0;
    else if (carry_o) ms_q <= '0;
    else if (tick_i)  ms_q <= ms_q + 1'b1;
  end

  p_ms_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q <= MS_LAST)
    else $error("milliseconds out of range");

  p_ms_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(ms_q))
    else $error("milliseconds moved without a tick");

  p_ms_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ms_q == '0))
    else $error("preload did not clear milliseconds");
endmodule

// File: rtl/rtc_sec_shadow.sv
module rtc_sec_shadow #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              carry_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              snap_i,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] shadow_o
);
  logic [DATA_W-1:0] sec_q;
  logic [DATA_W-1:0] shadow_q;

  assign sec_o    = sec_q;
  assign shadow_o = shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sec_q <= '0;
    else if (load_i)  sec_q <= load_val_i;
    else if (carry_i) sec_q <= sec_q + 1'b1;
  end

  // snapshot takes the pre-edge seconds, so it pairs with the pre-edge ms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (snap_i) shadow_q <= sec_q;
  end

  p_snap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (shadow_q == $past(sec_q)))
    else $error("shadow did not capture seconds");

  p_shadow_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(shadow_q))
    else $error("shadow changed without a snapshot");

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_q == $past(load_val_i)))
    else $error("seconds preload lost");
endmodule

// File: rtl/rtc_ms_shadow.sv
module rtc_ms_shadow
  import rtc_ms_pkg::*;
#(
  parameter int TICK_DIV   = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int DATA_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int MS_W = $clog2(MS_PER_SEC);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  reg_sel_e          sel;
  logic              rd_en;
  logic              sec_load;
  logic              ms_snap;
  logic              tick;
  logic              carry;
  logic [MS_W-1:0]   ms_val;
  logic [DATA_W-1:0] sec_val;
  logic [DATA_W-1:0] shadow_val;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  assign sel      = decode_addr(addr_i);
  assign rd_en    = req_i && !we_i;
  assign sec_load = req_i && we_i && (sel == SEL_SEC);
  assign ms_snap  = rd_en && (sel == SEL_MS);

  rtc_tick_gen #(
    .TICK_DIV (TICK_DIV)
  ) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (sec_load),
    .tick_o    (tick)
  );

  rtc_ms_count #(
    .MS_PER_SEC (MS_PER_SEC)
  ) u_ms (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .clr_i   (sec_load),
    .ms_o    (ms_val),
    .carry_o (carry)
  );

  rtc_sec_shadow #(
    .DATA_W (DATA_W)
  ) u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .carry_i    (carry),
    .load_i     (sec_load),
    .load_val_i (wdata_i),
    .snap_i     (ms_snap),
    .sec_o      (sec_val),
    .shadow_o   (shadow_val)
  );

  always_comb begin
    unique case (sel)
      SEL_SEC:    rdata_d = sec_val;
      SEL_SHADOW: rdata_d = shadow_val;
      SEL_MS:     rdata_d = DATA_W'(ms_val);
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  p_rollover_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (ms_val == MS_LAST) && !sec_load) |=>
      ((sec_val == $past(sec_val) + 1'b1) && (ms_val == '0)))
    else $error("rollover did not advance seconds");

  p_sec_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (ms_val == MS_LAST) && !sec_load && (&sec_val)) |=> (sec_val == '0))
    else $error("seconds did not wrap");

  p_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && (sel == SEL_NONE)) |=> (rdata_o == '0))
    else $error("unmapped read returned data");

  p_write_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (sel != SEL_SEC)) |=> $stable(shadow_val))
    else $error("ignored write touched shadow");
endmodule

// File: tb/rtc_ms_shadow_tb.sv
module rtc_ms_shadow_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int MS_PS      = 1000;
  localparam int CYC_PER_S  = TICK_DIV * MS_PS;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int          cyc = 0;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  // preload model state
  int          w_edge = 0;
  logic [31:0] base = '0;
  logic [31:0] exp_shadow = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  rtc_ms_shadow #(
    .TICK_DIV   (TICK_DIV),
    .MS_PER_SEC (MS_PS),
    .DATA_W     (32)
  ) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  // elapsed ms before edge e
  function automatic int elapsed(int e);
    return (e - 1 - w_edge) / TICK_DIV;
  endfunction
  function automatic logic [31:0] exp_ms(int e);
    return 32'(elapsed(e) % MS_PS);
  endfunction
  function automatic logic [31:0] exp_sec(int e);
    return base + 32'(elapsed(e) / MS_PS);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // call right after a negedge; returns after the next negedge
  task automatic rd(logic [7:0] a, output logic [31:0] d, output int e);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
    e = cyc;
    if (a == 8'h10) exp_shadow = exp_sec(e);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] v);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = v;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    if (a == 8'h08) begin
      w_edge = cyc;
      base = v;
    end
  endtask

  task automatic wait_until(int target);
    while (cyc < target) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int e;
    logic [31:0] held;

    repeat (3) @(negedge clk_i);
    chk("R9 rdata in reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5: shadow starts at zero; R8 unmapped reads
    rd(8'h0C, d, e); chk("R5 shadow reset", d, 32'h0);
    rd(8'h04, d, e); chk("R8 unmapped 0x04", d, 32'h0);
    rd(8'h14, d, e); chk("R8 unmapped 0x14", d, 32'h0);
    rd(8'h00, d, e); chk("R8 unmapped 0x00", d, 32'h0);
    rd(8'hFF, d, e); chk("R8 unmapped 0xFF", d, 32'h0);

    // R6 preload then R1/R2 exhaustive ms sweep across two rollovers
    wr(8'h08, 32'd5);
    rd(8'h08, d, e); chk("R6 preload seconds", d, 32'd5);
    for (int i = 0; i < 2 * CYC_PER_S + 200; i++) begin
      rd(8'h10, d, e);
      chk("R1 ms sweep", d, exp_ms(e));
    end
    rd(8'h0C, d, e); chk("R4 shadow after sweep", d, exp_shadow);
    rd(8'h08, d, e); chk("R2 seconds after two rollovers", d, exp_sec(e));
    chk("R2 seconds value", d, 32'd7);

    // R6: restart of prescaler, ms 0,0,1 after the write edge
    wr(8'h08, 32'd40);
    rd(8'h10, d, e); chk("R6 ms cleared", d, 32'd0);
    rd(8'h10, d, e); chk("R6 first period", d, 32'd0);
    rd(8'h10, d, e); chk("R6 first tick", d, 32'd1);

    // R4: ms read on the rollover edge, then shadow, then live seconds
    wr(8'h08, 32'd100);
    wait_until(w_edge + CYC_PER_S - 1);
    rd(8'h10, d, e); chk("R4 ms on rollover edge", d, 32'd999);
    rd(8'h0C, d, e); chk("R4 shadow old second", d, 32'd100);
    rd(8'h08, d, e); chk("R2 live seconds advanced", d, 32'd101);
    rd(8'h10, d, e); chk("R2 ms wrapped", d, exp_ms(e));

    // R5: shadow holds across a rollover without a ms read
    held = exp_shadow;
    wait_until(cyc + CYC_PER_S + 10);
    rd(8'h08, d, e); chk("R10 seconds kept counting", d, exp_sec(e));
    rd(8'h0C, d, e); chk("R5 shadow held", d, held);

    // R7: ignored writes
    wr(8'h0C, 32'hDEAD_BEEF);
    wr(8'h10, 32'h0000_03FF);
    wr(8'h04, 32'h1234_5678);
    rd(8'h0C, d, e); chk("R7 shadow unchanged", d, held);
    rd(8'h08, d, e); chk("R7 seconds unchanged", d, exp_sec(e));
    rd(8'h10, d, e); chk("R7 ms not cleared", d, exp_ms(e));

    // R6: preload lands on a rollover edge and wins
    wait_until(w_edge + 3 * CYC_PER_S - 1);
    wr(8'h08, 32'd500);
    rd(8'h10, d, e); chk("R6 ms zero after coincident load", d, 32'd0);
    rd(8'h08, d, e); chk("R6 load beats rollover", d, 32'd500);
    rd(8'h10, d, e); chk("R6 tick after restart", d, 32'd1);

    // R3: wrap modulo 2^32
    wr(8'h08, 32'hFFFF_FFFF);
    wait_until(w_edge + CYC_PER_S + 20);
    rd(8'h08, d, e); chk("R3 seconds wrap", d, 32'h0);
    rd(8'h10, d, e); chk("R3 ms after wrap", d, exp_ms(e));
    rd(8'h0C, d, e); chk("R4 shadow after wrap", d, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule